// File: doc/BRIEF.md
# RAM Controller Error-Status and Interrupt Register Block

This block is the software-visible control and status face of an on-chip RAM controller that protects its array with ECC. A simple word-wide register port gives access to a set of control registers, an interrupt status register, an interrupt mask, two error-capture channels and an implementation register. The implementation register reports the configured RAM size as a small code. The ECC datapath and the RAM array sit outside this block. They report error events and first-failure details through hardware inputs.

Every access is carried by a three-state bus sequencer. In BUS_IDLE a one-cycle request is latched. The sequencer always moves from BUS_IDLE to BUS_EXEC when a request is seen. In BUS_EXEC the write strobe fires or the read word is registered. The sequencer always moves from BUS_EXEC to BUS_RESP, where the acknowledge is raised for one cycle. It then always returns from BUS_RESP to BUS_IDLE. The interrupt mask cannot be written directly: software unmasks sources through an enable register and masks them through a disable register. A single level interrupt output is raised whenever an unmasked status bit is set.

Each capture channel (correctable and uncorrectable) records a failing address and syndrome only while its status bit is clear. Further failures therefore cannot overwrite the first failure until software acknowledges it.

Top module: `ramc_regs`

## Requirements
- R1: A request seen in BUS_IDLE is acknowledged by `ack_o` for exactly one cycle, two clock edges after the edge that sampled it. Requests made while the sequencer is busy are ignored.
- R2: After reset: error control reads 0xF, status reads 0, mask reads 0x7FF, ECC control, clear and fault counter read 0, and `irq_o` is low.
- R3: Word offset 1 is the 11-bit interrupt status. An event input bit sets its status bit, and writing 1 to a bit clears it. Bits 31:11 always read 0.
- R4: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask at offset 2 ignores direct writes.
- R6: Writing to the enable register at offset 3 clears the mask bits that are 1 in the written value. Offset 3 always reads 0.
- R7: Writing to the disable register at offset 4 sets the mask bits that are 1 in the written value. Offset 4 always reads 0.
- R8: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0. It follows each status, enable and disable write.
- R9: Error control (offset 0) keeps 4 bits, ECC control (offset 5) 3 bits, clear (offset 6) 8 bits and the fault counter (offset 11) 24 bits. The remaining bits read 0.
- R10: An access whose byte enables are not all four set neither writes anything and reads 0.
- R11: A capture strobe sets its status bit: bit 0 for correctable, bit 1 for uncorrectable. It loads the 20-bit address (offsets 7 and 9) and the 16-bit syndrome (offsets 8 and 10) only while that status bit is clear.
- R12: Offset 12 reads the size code in bits 3:0 (64, 128, 256, 512, 1024 KiB give 0 to 4; 1024 KiB by default reads 4) and ignores writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (6) | Word offset |
| be_i | input | 4 | Byte enables, must be 4'hF |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access complete, one cycle |
| rdata_o | output | 32 | Read data, valid with ack_o |
| evt_i | input | NUM_SRC (11) | Hardware error events, one per status bit |
| ce_cap_i | input | 1 | Correctable-error capture strobe |
| ce_addr_i | input | FADDR_W (20) | Correctable failing address |
| ce_syn_i | input | SYN_W (16) | Correctable syndrome |
| ue_cap_i | input | 1 | Uncorrectable-error capture strobe |
| ue_addr_i | input | FADDR_W (20) | Uncorrectable failing address |
| ue_syn_i | input | SYN_W (16) | Uncorrectable syndrome |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench collides an event with a write-1-to-clear of the same bit. A design that lets the clear win would silently drop an error. It also writes the mask directly and checks the value is unchanged, which exposes a design that decodes the mask as writable. The enable and disable registers are read back as zero after being written, and the interrupt is checked as bits are unmasked and masked again. This catches inverted set/clear sense or a missing re-evaluation. A second capture while the status bit is set must leave the first address and syndrome in place, exposing a design that overwrites the first failure. Partial-width writes must leave the target untouched, catching a missing byte-enable check.

// File: rtl/ramc_pkg.sv
package ramc_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_EXEC = 2'd1,
        BUS_RESP = 2'd2
    } bus_state_e;

    localparam int unsigned OFF_ERRCTL = 0;
    localparam int unsigned OFF_STAT   = 1;
    localparam int unsigned OFF_MASK   = 2;
    localparam int unsigned OFF_IEN    = 3;
    localparam int unsigned OFF_IDIS   = 4;
    localparam int unsigned OFF_ECC    = 5;
    localparam int unsigned OFF_CLR    = 6;
    localparam int unsigned OFF_CE_ADR = 7;
    localparam int unsigned OFF_CE_SYN = 8;
    localparam int unsigned OFF_UE_ADR = 9;
    localparam int unsigned OFF_UE_SYN = 10;
    localparam int unsigned OFF_FICNT  = 11;
    localparam int unsigned OFF_IMPL   = 12;

    function automatic logic [2:0] size_code(input int unsigned kib);
        case (kib)
            64:      return 3'd0;
            128:     return 3'd1;
            256:     return 3'd2;
            512:     return 3'd3;
            1024:    return 3'd4;
            default: return 3'd7;
        endcase
    endfunction

    function automatic bit size_ok(input int unsigned kib);
        return size_code(kib) != 3'd7;
    endfunction

endpackage

// File: rtl/ramc_bus_fsm.sv
module ramc_bus_fsm #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic                    wr_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [DW/8-1:0]         be_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [DW-1:0]           rd_word_i,
    output logic [AW-1:0]           addr_o,
    output logic [DW-1:0]           wdata_o,
    output logic                    wstb_o,
    output logic                    ack_o,
    output logic [DW-1:0]           rdata_o,
    output ramc_pkg::bus_state_e    state_o
);
    import ramc_pkg::*;

    localparam int BEW = DW / 8;

    bus_state_e        state_q, state_d;
    logic              wr_q;
    logic [BEW-1:0]    be_q;
    logic              full_word;

    assign full_word = (be_q == {BEW{1'b1}});
    assign state_o   = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = BUS_EXEC;
            BUS_EXEC: state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // request capture and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            be_q    <= '0;
            addr_o  <= '0;
            wdata_o <= '0;
            rdata_o <= '0;
        end else begin
            unique case (state_q)
                BUS_IDLE: if (req_i) begin
                    wr_q    <= wr_i;
                    be_q    <= be_i;
                    addr_o  <= addr_i;
                    wdata_o <= wdata_i;
                end
                BUS_EXEC: rdata_o <= (!wr_q && full_word) ? rd_word_i : '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wstb_o = 1'b0;
        ack_o  = 1'b0;
        unique case (state_q)
            BUS_EXEC: wstb_o = wr_q && full_word;
            BUS_RESP: ack_o  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ramc_irq_ctrl.sv
module ramc_irq_ctrl #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_stb_i,
    input  logic               ien_stb_i,
    input  logic               ids_stb_i,
    input  logic [NUM_SRC-1:0] wbits_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] clr_bits;

    assign clr_bits = clr_stb_i ? wbits_i : '0;

    // new events are OR-ed after the clear so that they win
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_bits) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '1;
        else if (ids_stb_i) mask_o <= mask_o | wbits_i;
        else if (ien_stb_i) mask_o <= mask_o & ~wbits_i;
    end

    assign irq_o = |(status_o & ~mask_o);

endmodule

// File: rtl/ramc_capture.sv
module ramc_capture #(
    parameter int FADDR_W = 20,
    parameter int SYN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic               held_i,
    input  logic [FADDR_W-1:0] addr_i,
    input  logic [SYN_W-1:0]   syn_i,
    output logic [FADDR_W-1:0] addr_o,
    output logic [SYN_W-1:0]   syn_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            syn_o  <= '0;
        end else if (cap_i && !held_i) begin
            addr_o <= addr_i;
            syn_o  <= syn_i;
        end
    end
endmodule

// File: rtl/ramc_regs.sv
module ramc_regs #(
    parameter int unsigned RAM_KIB = 1024,
    parameter int NUM_SRC = 11,
    parameter int AW      = 6,
    parameter int FADDR_W = 20,
    parameter int SYN_W   = 16,
    parameter int FI_W    = 24,
    parameter int CE_BIT  = 0,
    parameter int UE_BIT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               wr_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [3:0]         be_i,
    input  logic [31:0]        wdata_i,
    output logic               ack_o,
    output logic [31:0]        rdata_o,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               ce_cap_i,
    input  logic [FADDR_W-1:0] ce_addr_i,
    input  logic [SYN_W-1:0]   ce_syn_i,
    input  logic               ue_cap_i,
    input  logic [FADDR_W-1:0] ue_addr_i,
    input  logic [SYN_W-1:0]   ue_syn_i,
    output logic               irq_o
);
    import ramc_pkg::*;

    localparam int DW      = 32;
    localparam int NCH     = 2;
    localparam int ERR_W   = 4;
    localparam int ECC_W   = 3;
    localparam int CLR_W   = 8;
    localparam logic [2:0] SIZE_CODE = size_code(RAM_KIB);

    if (!size_ok(RAM_KIB)) begin : g_bad_size
        $fatal(1, "ramc_regs: unsupported RAM size");
    end

    bus_state_e                   bus_st;
    logic [AW-1:0]                wr_addr;
    logic [DW-1:0]                wr_data;
    logic                         wr_stb;
    logic [DW-1:0]                rd_word;
    logic [NUM_SRC-1:0]           stat_w, mask_w, set_w;
    logic [ERR_W-1:0]             errctl_q;
    logic [ECC_W-1:0]             ecc_q;
    logic [CLR_W-1:0]             clr_q;
    logic [FI_W-1:0]              ficnt_q;
    logic [NCH-1:0]               cap_v;
    logic [NCH-1:0][FADDR_W-1:0]  cap_addr_in, cap_addr_w;
    logic [NCH-1:0][SYN_W-1:0]    cap_syn_in, cap_syn_w;
    logic [NCH-1:0]               cap_held;

    ramc_bus_fsm #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .be_i      (be_i),
        .wdata_i   (wdata_i),
        .rd_word_i (rd_word),
        .addr_o    (wr_addr),
        .wdata_o   (wr_data),
        .wstb_o    (wr_stb),
        .ack_o     (ack_o),
        .rdata_o   (rdata_o),
        .state_o   (bus_st)
    );

    assign cap_v       = {ue_cap_i, ce_cap_i};
    assign cap_addr_in = {ue_addr_i, ce_addr_i};
    assign cap_syn_in  = {ue_syn_i, ce_syn_i};
    assign cap_held    = {stat_w[UE_BIT], stat_w[CE_BIT]};

    always_comb begin
        set_w         = evt_i;
        set_w[CE_BIT] = set_w[CE_BIT] | ce_cap_i;
        set_w[UE_BIT] = set_w[UE_BIT] | ue_cap_i;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cap
        ramc_capture #(.FADDR_W(FADDR_W), .SYN_W(SYN_W)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (cap_v[c]),
            .held_i (cap_held[c]),
            .addr_i (cap_addr_in[c]),
            .syn_i  (cap_syn_in[c]),
            .addr_o (cap_addr_w[c]),
            .syn_o  (cap_syn_w[c])
        );
    end

    ramc_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_w),
        .clr_stb_i (wr_stb && wr_addr == AW'(OFF_STAT)),
        .ien_stb_i (wr_stb && wr_addr == AW'(OFF_IEN)),
        .ids_stb_i (wr_stb && wr_addr == AW'(OFF_IDIS)),
        .wbits_i   (wr_data[NUM_SRC-1:0]),
        .status_o  (stat_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );

    // plain control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            errctl_q <= '1;
            ecc_q    <= '0;
            clr_q    <= '0;
            ficnt_q  <= '0;
        end else if (wr_stb) begin
            case (wr_addr)
                AW'(OFF_ERRCTL): errctl_q <= wr_data[ERR_W-1:0];
                AW'(OFF_ECC):    ecc_q    <= wr_data[ECC_W-1:0];
                AW'(OFF_CLR):    clr_q    <= wr_data[CLR_W-1:0];
                AW'(OFF_FICNT):  ficnt_q  <= wr_data[FI_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_word = '0;
        case (wr_addr)
            AW'(OFF_ERRCTL): rd_word = DW'(errctl_q);
            AW'(OFF_STAT):   rd_word = DW'(stat_w);
            AW'(OFF_MASK):   rd_word = DW'(mask_w);
            AW'(OFF_ECC):    rd_word = DW'(ecc_q);
            AW'(OFF_CLR):    rd_word = DW'(clr_q);
            AW'(OFF_CE_ADR): rd_word = DW'(cap_addr_w[0]);
            AW'(OFF_CE_SYN): rd_word = DW'(cap_syn_w[0]);
            AW'(OFF_UE_ADR): rd_word = DW'(cap_addr_w[1]);
            AW'(OFF_UE_SYN): rd_word = DW'(cap_syn_w[1]);
            AW'(OFF_FICNT):  rd_word = DW'(ficnt_q);
            AW'(OFF_IMPL):   rd_word = DW'(SIZE_CODE);
            default:         rd_word = '0;
        endcase
    end

endmodule

// File: rtl/ramc_regs_chk.sv
module ramc_regs_chk #(
    parameter int NUM_SRC = 11,
    parameter int AW      = 6,
    parameter int FADDR_W = 20,
    parameter int CE_BIT  = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_i,
    input logic                 ack_o,
    input logic                 irq_o,
    input logic [NUM_SRC-1:0]   evt_i,
    input ramc_pkg::bus_state_e bus_st,
    input logic                 wr_stb,
    input logic [AW-1:0]        wr_addr,
    input logic [NUM_SRC-1:0]   stat_w,
    input logic [NUM_SRC-1:0]   mask_w,
    input logic [FADDR_W-1:0]   ce_addr_q
);
    import ramc_pkg::*;

    p_ack_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == BUS_IDLE && req_i) |=> ##1 ack_o);

    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_w & $past(evt_i)) == $past(evt_i)));

    p_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && (wr_addr == AW'(OFF_IEN) || wr_addr == AW'(OFF_IDIS)))
        |=> $stable(mask_w));

    p_first_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w[CE_BIT] |=> $stable(ce_addr_q));

    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '1) |-> !irq_o);

endmodule

bind ramc_regs ramc_regs_chk #(
    .NUM_SRC (NUM_SRC),
    .AW      (AW),
    .FADDR_W (FADDR_W),
    .CE_BIT  (CE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .ack_o     (ack_o),
    .irq_o     (irq_o),
    .evt_i     (evt_i),
    .bus_st    (bus_st),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .stat_w    (stat_w),
    .mask_w    (mask_w),
    .ce_addr_q (cap_addr_w[0])
);

// File: tb/tb_ramc_regs.sv
module tb_ramc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, wr_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [3:0]  be_i = '0;
    logic [31:0] wdata_i = '0;
    logic        ack_o;
    logic [31:0] rdata_o;
    logic [10:0] evt_i = '0;
    logic        ce_cap_i = 1'b0, ue_cap_i = 1'b0;
    logic [19:0] ce_addr_i = '0, ue_addr_i = '0;
    logic [15:0] ce_syn_i = '0, ue_syn_i = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit          rdq[$];
    logic [31:0] expq[$];
    string       tagq[$];

    always #4 clk = ~clk;

    ramc_regs dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .be_i(be_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
        .evt_i(evt_i), .ce_cap_i(ce_cap_i), .ce_addr_i(ce_addr_i), .ce_syn_i(ce_syn_i),
        .ue_cap_i(ue_cap_i), .ue_addr_i(ue_addr_i), .ue_syn_i(ue_syn_i), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && ack_o) begin
            if (rdq.size() == 0) check(32'd1, 32'd0, "R1 unexpected ack");
            else begin
                automatic bit          r = rdq.pop_front();
                automatic logic [31:0] e = expq.pop_front();
                automatic string       t = tagq.pop_front();
                if (r) check(rdata_o, e, t);
            end
        end
    end

    // driver: one access; evt is applied during the execute cycle
    task automatic acc(input bit wr, input int a, input logic [31:0] d, input logic [3:0] be,
                       input logic [31:0] exp, input logic [10:0] evt, input string tag);
        rdq.push_back(!wr); expq.push_back(exp); tagq.push_back(tag);
        @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = 6'(a); be_i = be; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; evt_i = evt;
        @(negedge clk);
        evt_i = '0;
        check({31'd0, ack_o}, 32'd1, "R1 ack timing");
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        acc(1'b1, a, d, 4'hF, 32'd0, 11'd0, "wr");
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        acc(1'b0, a, 32'd0, 4'hF, exp, 11'd0, tag);
    endtask

    task automatic cap(input bit ue, input logic [19:0] a, input logic [15:0] s);
        @(negedge clk);
        if (ue) begin ue_cap_i = 1'b1; ue_addr_i = a; ue_syn_i = s; end
        else    begin ce_cap_i = 1'b1; ce_addr_i = a; ce_syn_i = s; end
        @(negedge clk);
        ce_cap_i = 1'b0; ue_cap_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        check({31'd0, irq_o}, 32'd0, "R2 irq after reset");
        rd(0, 32'hF, "R2 errctl reset");
        rd(1, 32'h0, "R2 status reset");
        rd(2, 32'h7FF, "R2 mask reset");
        rd(5, 32'h0, "R2 ecc reset");
        rd(11, 32'h0, "R2 fault counter reset");
        // R12 size code and unmapped
        rd(12, 32'h4, "R12 size code");
        wr(12, 32'h0);
        rd(12, 32'h4, "R12 size code write ignored");
        rd(20, 32'h0, "R12 unmapped read");
        // R3 events and write-1-to-clear
        acc(1'b1, 20, 32'h0, 4'hF, 32'd0, 11'h405, "R3 evt");
        rd(1, 32'h405, "R3 events set status");
        check({31'd0, irq_o}, 32'd0, "R8 all masked");
        wr(1, 32'hFFFF_F001);
        rd(1, 32'h404, "R3 w1c bit0 and reserved zero");
        // R5 direct mask write ignored
        wr(2, 32'h0);
        rd(2, 32'h7FF, "R5 mask not writable");
        // R6 enable
        wr(3, 32'h004);
        rd(2, 32'h7FB, "R6 enable clears mask bit");
        rd(3, 32'h0, "R6 enable reads zero");
        check({31'd0, irq_o}, 32'd1, "R8 irq on unmask");
        // R4 set wins over clear
        acc(1'b1, 1, 32'h004, 4'hF, 32'd0, 11'h004, "R4 collide");
        rd(1, 32'h404, "R4 event wins over clear");
        check({31'd0, irq_o}, 32'd1, "R8 irq still high");
        wr(1, 32'h004);
        rd(1, 32'h400, "R3 clear bit2");
        check({31'd0, irq_o}, 32'd0, "R8 irq low after clear");
        // R7 disable
        wr(4, 32'h004);
        rd(2, 32'h7FF, "R7 disable sets mask bit");
        rd(4, 32'h0, "R7 disable reads zero");
        wr(3, 32'h400);
        check({31'd0, irq_o}, 32'd1, "R8 irq on bit10 unmask");
        wr(4, 32'h400);
        check({31'd0, irq_o}, 32'd0, "R8 irq low after disable");
        // R9 widths
        wr(0, 32'h0);
        rd(0, 32'h0, "R9 errctl write");
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'hF, "R9 errctl 4 bits");
        wr(5, 32'hFFFF_FFFF);
        rd(5, 32'h7, "R9 ecc 3 bits");
        wr(6, 32'hFFFF_FFFF);
        rd(6, 32'hFF, "R9 clear 8 bits");
        wr(11, 32'hFFFF_FFFF);
        rd(11, 32'hFF_FFFF, "R9 fault counter 24 bits");
        // R10 partial access
        acc(1'b1, 0, 32'h0, 4'h3, 32'd0, 11'd0, "R10 partial write");
        rd(0, 32'hF, "R10 partial write ignored");
        acc(1'b0, 0, 32'h0, 4'h1, 32'h0, 11'd0, "R10 partial read zero");
        // R11 capture
        wr(1, 32'h7FF);
        cap(1'b0, 20'hABCDE, 16'h1234);
        rd(7, 32'hABCDE, "R11 ce address");
        rd(8, 32'h1234, "R11 ce syndrome");
        rd(1, 32'h001, "R11 ce sets status bit0");
        cap(1'b0, 20'h11111, 16'h5555);
        rd(7, 32'hABCDE, "R11 first ce address kept");
        rd(8, 32'h1234, "R11 first ce syndrome kept");
        wr(1, 32'h001);
        cap(1'b0, 20'h11111, 16'h5555);
        rd(7, 32'h11111, "R11 ce reload after clear");
        cap(1'b1, 20'h22222, 16'hBEEF);
        rd(9, 32'h22222, "R11 ue address");
        rd(10, 32'hBEEF, "R11 ue syndrome");
        rd(1, 32'h003, "R11 ue sets status bit1");
        repeat (4) @(negedge clk);
        check(32'(rdq.size()), 32'd0, "R1 scoreboard drained");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule